// File: doc/BRIEF.md
# SDRAM Mode-Register Command Sequencer

This block sits inside a memory controller and issues mode-register-set commands to an external SDRAM that is split into four partitions. The partitions are handled as two pairs. A CPU write to the low-power mode register starts a sequence of two stages. Stage one serves partitions 0 and 1, and stage two serves partitions 2 and 3. In each stage the stored value is driven onto the 15 row-address lines for one clock. During that clock the command strobes carry the mode-register-set encoding, and the chip select of each qualified partition is pulled low.

The low-power value holds the partial-array and temperature-compensated self-refresh settings. It has no effect inside the controller. A second register, the standard mode register, can be read back by the CPU. Its burst-length and burst-type fields are wired to fixed values. Its CAS-latency fields copy the timing-category configuration inputs. A busy flag covers a running sequence. A low-power write that arrives while the flag is high is held and runs as a fresh sequence after the current one.

Top module: `sdram_mrs_sequencer`

## Requirements
- R1: A write with `reg_sel`=0 while idle starts a sequence. Stage one's command appears in the cycle after the write. `busy` is high from that cycle through stage two's command cycle and is low in the cycle after it.
- R2: In a command cycle `ras_n`, `cas_n` and `we_n` are all 0. In every other cycle all three are 1. Each stage lasts exactly one cycle.
- R3: In each command cycle `ma` carries bits 14:0 of the low-power value. Outside command cycles `ma` is 0.
- R4: Stage one may drive only `cs_n[1:0]` and stage two may drive only `cs_n[3:2]`. `cs_n[x]` goes low only when `bank_en[x]` is 1 and bit 16+x of the low-power value is 1. Outside command cycles `cs_n` is 4'hF.
- R5: Between the two commands there are exactly G idle cycles, where G is `mrd_gap` or MIN_MRD (default 2), whichever is larger. A stage in which no chip select qualifies still uses its slot, with `cs_n`=4'hF.
- R6: The low-power register keeps bits 19:16 and 14:0. All its other bits read 0 when `reg_sel`=0. A new value takes effect and becomes readable when its sequence starts.
- R7: In the standard register (`reg_sel`=1), bits 2:0 and 18:16 always read 3'b010 (burst of four). Bits 3 and 19 always read 0 (sequential). Writes do not change these bits.
- R8: Standard-register bits 6:4 copy `cl_cat0` and bits 22:20 copy `cl_cat2`. Bits 14:7 and 30:23 are writable, and bits 15 and 31 read 0. With both category inputs at 2, the value after reset is 32'h0022_0022. Writing this register starts no command.
- R9: A low-power write made while `busy` is high does not change the running sequence. After stage two there are G idle cycles, then a new sequence runs with the newest held value. `busy` stays high for the whole time.
- R10: While `rst_n` is low and after its release, `busy` is 0, `cs_n` is 4'hF, the command strobes are 1 and the low-power register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 low-power, 1 standard |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| bank_en | input | 4 | Per-partition bank enable from configuration |
| cl_cat0 | input | 3 | Timing category of pair 0 (CAS latency) |
| cl_cat2 | input | 3 | Timing category of pair 2 (CAS latency) |
| mrd_gap | input | 4 | Requested idle cycles between stages |
| busy | output | 1 | Sequence in progress or pending |
| ma | output | 15 | Row-address lines |
| cs_n | output | 4 | Active-low chip selects, one per partition |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |

## Verification
The bench walks several mixes of bank enables and per-partition enable bits. These include a mix in which neither stage qualifies any partition. A design that ignored one of the two gates, or that swapped the pairs, would pull down the wrong chip selects. A design that skipped an empty stage would give a sequence that is too short. Gap requests of zero, one and fifteen check the clamp to MIN_MRD: an off-by-one in the gap counter would move the stage-two command by a cycle. A write made during stage one checks that the running address is not corrupted, that busy does not drop, and that the second sequence keeps its own spacing. Register reads check the fixed burst fields against writes of all ones, and check that the CAS-latency fields follow their inputs.

// File: rtl/mrs_seq_pkg.sv
package mrs_seq_pkg;

  // Register layout (fixed: the SDRAM decodes these fields)
  localparam int REG_W   = 32;
  localparam int ADDR_W  = 15;
  localparam int NPART   = 4;
  localparam int EN_LSB  = 16;
  localparam logic [REG_W-1:0] LP_KEEP_MASK = 32'h000F_7FFF;
  localparam logic [2:0] BURST_FOUR = 3'b010;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_ST1  = 2'd1,
    S_GAP  = 2'd2,
    S_ST2  = 2'd3
  } seq_st_e;

  // Low-power value as stored: unused bits cleared
  function automatic logic [REG_W-1:0] lp_keep(input logic [REG_W-1:0] w);
    return w & LP_KEEP_MASK;
  endfunction

  // Standard register as read: writable bytes plus fixed and mirrored fields
  function automatic logic [REG_W-1:0] std_view(input logic [7:0] q0,
                                               input logic [7:0] q2,
                                               input logic [2:0] cl0,
                                               input logic [2:0] cl2);
    return {1'b0, q2, cl2, 1'b0, BURST_FOUR, 1'b0, q0, cl0, 1'b0, BURST_FOUR};
  endfunction

endpackage

// File: rtl/mrs_lp_reg.sv
module mrs_lp_reg
  import mrs_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  input  logic             busy,
  input  logic             take,
  output logic [REG_W-1:0] lp_q,
  output logic             pend
);

  logic [REG_W-1:0] held_q;
  logic             pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lp_q   <= '0;
      held_q <= '0;
      pend_q <= 1'b0;
    end else begin
      if (take) begin
        lp_q   <= held_q;
        pend_q <= 1'b0;
      end
      if (wr && !busy) begin
        lp_q <= lp_keep(wdata);
      end else if (wr) begin
        held_q <= lp_keep(wdata);
        pend_q <= 1'b1;
      end
    end
  end

  assign pend = pend_q;

  // R9
  pend_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> busy);

endmodule

// File: rtl/mrs_std_reg.sv
module mrs_std_reg
  import mrs_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [7:0]       wq0,
  input  logic [7:0]       wq2,
  input  logic [2:0]       cl0,
  input  logic [2:0]       cl2,
  output logic [REG_W-1:0] rdata
);

  logic [7:0] q0_q, q2_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q0_q <= '0;
      q2_q <= '0;
    end else if (wr) begin
      q0_q <= wq0;
      q2_q <= wq2;
    end
  end

  assign rdata = std_view(q0_q, q2_q, cl0, cl2);

endmodule

// File: rtl/mrs_stage_fsm.sv
module mrs_stage_fsm
  import mrs_seq_pkg::*;
#(
  parameter int GAP_W   = 4,
  parameter int MIN_MRD = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lp_wr,
  input  logic             pend,
  input  logic [GAP_W-1:0] mrd_gap,
  output logic             busy,
  output logic             st1_cmd,
  output logic             st2_cmd,
  output logic             take_pend
);

  localparam logic [GAP_W-1:0] MIN_G = GAP_W'(MIN_MRD);

  function automatic logic [GAP_W-1:0] gap_len(input logic [GAP_W-1:0] g);
    return (g < MIN_G) ? MIN_G : g;
  endfunction

  seq_st_e          st_q, st_d;
  logic [GAP_W-1:0] cnt_q, cnt_d;
  logic             second_q, second_d;
  logic             gap_done;

  assign gap_done = (cnt_q == '0);

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    second_d  = second_q;
    take_pend = 1'b0;
    case (st_q)
      S_IDLE: if (lp_wr) st_d = S_ST1;
      S_ST1: begin
        st_d     = S_GAP;
        cnt_d    = gap_len(mrd_gap) - 1'b1;
        second_d = 1'b1;
      end
      S_GAP: begin
        if (gap_done) begin
          if (second_q) begin
            st_d = S_ST2;
          end else begin
            st_d      = S_ST1;
            take_pend = 1'b1;
          end
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      S_ST2: begin
        if (pend || lp_wr) begin
          st_d     = S_GAP;
          cnt_d    = gap_len(mrd_gap) - 1'b1;
          second_d = 1'b0;
        end else begin
          st_d = S_IDLE;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      cnt_q    <= '0;
      second_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      cnt_q    <= cnt_d;
      second_q <= second_d;
    end
  end

  assign busy    = (st_q != S_IDLE);
  assign st1_cmd = (st_q == S_ST1);
  assign st2_cmd = (st_q == S_ST2);

  // R5
  st1_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_ST1) |=> (st_q == S_GAP));

  // R5
  gap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_GAP) |-> (cnt_q < MIN_G || cnt_q <= gap_len(mrd_gap)));

endmodule

// File: rtl/mrs_cmd_drive.sv
module mrs_cmd_drive
  import mrs_seq_pkg::*;
(
  input  logic              st1_cmd,
  input  logic              st2_cmd,
  input  logic [ADDR_W-1:0] val,
  input  logic [NPART-1:0]  part_en,
  input  logic [NPART-1:0]  bank_en,
  output logic [ADDR_W-1:0] ma,
  output logic [NPART-1:0]  cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n
);

  logic cmd;
  assign cmd = st1_cmd | st2_cmd;

  for (genvar p = 0; p < NPART; p++) begin : g_cs
    logic stage_hit;
    if (p < NPART/2) begin : g_pair0
      assign stage_hit = st1_cmd;
    end else begin : g_pair1
      assign stage_hit = st2_cmd;
    end
    assign cs_n[p] = ~(stage_hit & bank_en[p] & part_en[p]);
  end

  assign ma    = cmd ? val : '0;
  assign ras_n = ~cmd;
  assign cas_n = ~cmd;
  assign we_n  = ~cmd;

endmodule

// File: rtl/sdram_mrs_sequencer.sv
module sdram_mrs_sequencer
  import mrs_seq_pkg::*;
#(
  parameter int GAP_W   = 4,
  parameter int MIN_MRD = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [NPART-1:0]  bank_en,
  input  logic [2:0]        cl_cat0,
  input  logic [2:0]        cl_cat2,
  input  logic [GAP_W-1:0]  mrd_gap,
  output logic              busy,
  output logic [ADDR_W-1:0] ma,
  output logic [NPART-1:0]  cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n
);

  logic             lp_wr, std_wr;
  logic [REG_W-1:0] lp_q, std_q;
  logic             pend, take_pend, st1_cmd, st2_cmd;

  assign lp_wr  = reg_wr & ~reg_sel;
  assign std_wr = reg_wr &  reg_sel;

  mrs_stage_fsm #(.GAP_W(GAP_W), .MIN_MRD(MIN_MRD)) u_fsm (
    .clk(clk), .rst_n(rst_n), .lp_wr(lp_wr), .pend(pend), .mrd_gap(mrd_gap),
    .busy(busy), .st1_cmd(st1_cmd), .st2_cmd(st2_cmd), .take_pend(take_pend)
  );

  mrs_lp_reg u_lp (
    .clk(clk), .rst_n(rst_n), .wr(lp_wr), .wdata(reg_wdata), .busy(busy),
    .take(take_pend), .lp_q(lp_q), .pend(pend)
  );

  mrs_std_reg u_std (
    .clk(clk), .rst_n(rst_n), .wr(std_wr),
    .wq0(reg_wdata[14:7]), .wq2(reg_wdata[30:23]),
    .cl0(cl_cat0), .cl2(cl_cat2), .rdata(std_q)
  );

  mrs_cmd_drive u_drv (
    .st1_cmd(st1_cmd), .st2_cmd(st2_cmd), .val(lp_q[ADDR_W-1:0]),
    .part_en(lp_q[EN_LSB +: NPART]), .bank_en(bank_en),
    .ma(ma), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n)
  );

  assign reg_rdata = reg_sel ? std_q : lp_q;

  // R1
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!ras_n && !cas_n && !we_n));

  // R2
  cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |=> ras_n);

  // R4
  cs_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n != {NPART{1'b1}}) |-> (!ras_n && busy));

  // R4
  pair_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n[1:0] != 2'b11) |-> (cs_n[3:2] == 2'b11));

endmodule

// File: tb/sdram_mrs_sequencer_test.sv
module sdram_mrs_sequencer_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr, reg_sel;
  logic [31:0] reg_wdata, reg_rdata;
  logic [3:0]  bank_en;
  logic [2:0]  cl_cat0, cl_cat2;
  logic [3:0]  mrd_gap;
  logic        busy;
  logic [14:0] ma;
  logic [3:0]  cs_n;
  logic        ras_n, cas_n, we_n;

  int n_chk = 0;
  int n_bad = 0;

  sdram_mrs_sequencer uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bank_en(bank_en),
    .cl_cat0(cl_cat0), .cl_cat2(cl_cat2), .mrd_gap(mrd_gap), .busy(busy),
    .ma(ma), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n)
  );

  always #4 clk = ~clk;

  typedef struct packed {
    logic [3:0]  bank;
    logic [3:0]  en;
    logic [14:0] addr;
    logic [3:0]  gap;
    logic [3:0]  cs1;
    logic [3:0]  cs2;
    logic [3:0]  g;
  } vec_t;

  localparam int NVEC = 5;
  localparam vec_t VEC [NVEC] = '{
    '{4'hF, 4'hF, 15'h0A5C, 4'd3,  4'hC, 4'h3, 4'd3},
    '{4'h5, 4'hF, 15'h7FFF, 4'd0,  4'hE, 4'hB, 4'd2},
    '{4'hF, 4'h6, 15'h0001, 4'd5,  4'hD, 4'hB, 4'd5},
    '{4'hC, 4'h3, 15'h1234, 4'd1,  4'hF, 4'hF, 4'd2},
    '{4'hA, 4'hF, 15'h4000, 4'd15, 4'hD, 4'h7, 4'd15}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_checks(input string req, input logic exp_busy);
    check(req, {29'd0, ras_n, cas_n, we_n}, 32'd7);
    check(req, {28'd0, cs_n}, 32'hF);
    check(req, {17'd0, ma}, 32'd0);
    check(req, {31'd0, busy}, {31'd0, exp_busy});
  endtask

  task automatic cmd_checks(input string req, input logic [14:0] a, input logic [3:0] cs);
    check(req, {29'd0, ras_n, cas_n, we_n}, 32'd0);
    check(req, {17'd0, ma}, {17'd0, a});
    check(req, {28'd0, cs_n}, {28'd0, cs});
    check(req, {31'd0, busy}, 32'd1);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
    bank_en = 4'hF; cl_cat0 = 3'd2; cl_cat2 = 3'd2; mrd_gap = 4'd2;
    repeat (3) @(negedge clk);
    // R10 during reset
    idle_checks("R10", 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    idle_checks("R10", 1'b0);
    check("R10 lp read", reg_rdata, 32'h0);
    reg_sel = 1'b1;
    #1;
    check("R8 reset value", reg_rdata, 32'h0022_0022);
    reg_sel = 1'b0;

    // Table walk: R1 R2 R3 R4 R5 R6
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      bank_en = VEC[v].bank; mrd_gap = VEC[v].gap;
      reg_sel = 1'b0; reg_wr = 1'b1;
      reg_wdata = {12'hABC, VEC[v].en, 1'b1, VEC[v].addr};
      @(negedge clk);
      reg_wr = 1'b0;
      cmd_checks("R1/R3/R4 stage one", VEC[v].addr, VEC[v].cs1);
      for (int i = 0; i < int'(VEC[v].g); i++) begin
        @(negedge clk);
        idle_checks("R5 gap", 1'b1);
      end
      @(negedge clk);
      cmd_checks("R2/R3/R4 stage two", VEC[v].addr, VEC[v].cs2);
      @(negedge clk);
      idle_checks("R1 end", 1'b0);
      check("R6 readback", reg_rdata, {12'h0, VEC[v].en, 1'b0, VEC[v].addr});
    end

    // R7 R8: standard register, writes of all ones
    @(negedge clk);
    cl_cat0 = 3'd3; cl_cat2 = 3'd5;
    reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    reg_wr = 1'b0;
    idle_checks("R8 no command", 1'b0);
    check("R7/R8 std read", reg_rdata,
          {1'b0, 8'hFF, 3'd5, 1'b0, 3'b010, 1'b0, 8'hFF, 3'd3, 1'b0, 3'b010});
    cl_cat0 = 3'd7; cl_cat2 = 3'd1;
    #1;
    check("R8 latency mirror", reg_rdata,
          {1'b0, 8'hFF, 3'd1, 1'b0, 3'b010, 1'b0, 8'hFF, 3'd7, 1'b0, 3'b010});
    reg_sel = 1'b0;

    // R9: write during stage one is held
    @(negedge clk);
    bank_en = 4'hF; mrd_gap = 4'd2;
    reg_wr = 1'b1; reg_wdata = {12'h0, 4'hF, 1'b0, 15'h1234};
    @(negedge clk);
    cmd_checks("R9 first stage one", 15'h1234, 4'hC);
    reg_wdata = {12'h0, 4'h5, 1'b0, 15'h0777};
    @(negedge clk);
    reg_wr = 1'b0;
    idle_checks("R9 gap", 1'b1);
    check("R6 held not visible", reg_rdata, {12'h0, 4'hF, 1'b0, 15'h1234});
    @(negedge clk);
    idle_checks("R9 gap", 1'b1);
    @(negedge clk);
    cmd_checks("R9 first stage two unchanged", 15'h1234, 4'h3);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      idle_checks("R9 recovery gap", 1'b1);
    end
    @(negedge clk);
    cmd_checks("R9 second stage one", 15'h0777, 4'hE);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      idle_checks("R9 gap", 1'b1);
    end
    @(negedge clk);
    cmd_checks("R9 second stage two", 15'h0777, 4'hB);
    @(negedge clk);
    idle_checks("R9 end", 1'b0);
    check("R6 new value", reg_rdata, {12'h0, 4'h5, 1'b0, 15'h0777});

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule